// File: doc/BRIEF.md
# Cross-partition reduction unit

This unit folds integer data that is spread over several partitions. Each partition is one row of `LANES` lanes, and each lane is `LANE_W` bits wide (8, 16 or 32). A job begins with a start pulse. The pulse carries an operation code, an arithmetic-or-bitwise variant bit, an axis select, a signed Q8.8 scale and an active-partition count. After the start pulse the unit accepts exactly `MAX_PARTS` rows on a valid/ready stream, one per cycle at most. Only the first rows, up to the count, enter the fold. It then presents the result and pulses `done`.

The six operations are sum, scaled sum (average), signed maximum, OR, AND and XOR. Sums use an accumulator of width `ACC_W`. `ACC_W` is twice the lane width for 8- and 16-bit lanes, and equal to the lane width for 32-bit lanes. The axis select chooses between two results:

- Folding the partition dimension only, which gives one value per lane.
- Collapsing everything into a single scalar, which is written to lane 0 only.

The combination order is not part of the contract.

Top module: `xpart_reduce`

## Requirements
- R1: After reset, `done`, `err`, `row_ready` and every bit of `res_we` are 0, and `res_data` is all zeros.
- R2: Operation codes are 0 sum, 1 average, 2 maximum, 3 OR, 4 AND, 5 XOR. `bitwise_sel` 0 selects the arithmetic variant and 1 the bitwise variant. Codes 0–2 are legal only with `bitwise_sel`=0, and codes 3–5 only with `bitwise_sel`=1. For codes 6 and 7, or any variant mismatch, `err` is high for exactly the cycle after the start pulse. In that case no row is accepted (`row_ready` stays 0) and `done` never rises.
- R3: A legal start in idle raises `row_ready` from the next cycle. The unit then accepts exactly `MAX_PARTS` rows, where cycles with `row_valid` low do not count. `done` and `res_we` are high for one cycle only, one cycle after the last row is accepted, and `res_data` holds its value until the next result.
- R4: Only the first `part_count` accepted rows enter the fold; later rows are accepted and ignored. A count above `MAX_PARTS` uses every row. A count of 0 gives the identity of the operation: 0 for sum, average, OR and XOR; all-ones for AND; the most negative lane value for maximum.
- R5: With `axis_sel`=1, output lane i (`res_data[i*ACC_W +: ACC_W]`) is the fold of lane i over the active partitions, and `res_we` is all ones.
- R6: With `axis_sel`=0, lane 0 holds the fold of every lane of every active partition. `res_we` is 1 on bit 0 only, and the other output lanes read zero.
- R7: Sum sign-extends each lane to `ACC_W` bits and wraps modulo 2^`ACC_W` (16 bits for 8-bit lanes, 32 for 16- and 32-bit lanes).
- R8: Average multiplies each signed lane by the signed Q8.8 `scale`. It shifts the product arithmetically right by 8 (truncating), takes it to `ACC_W` bits and sums it with wrap modulo 2^`ACC_W`.
- R9: Maximum compares lanes as signed values. The result occupies the low `LANE_W` bits of its output lane, and the upper bits are zero.
- R10: OR, AND and XOR act on the raw lane bits. The result occupies the low `LANE_W` bits, and the upper bits are zero.
- R11: A start pulse while a job is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job; sampled in idle |
| op_code | input | 3 | Operation code |
| bitwise_sel | input | 1 | 0 arithmetic variant, 1 bitwise variant |
| axis_sel | input | 1 | 0 scalar result, 1 per-lane result |
| scale | input | 16 | Signed Q8.8 multiplier for average |
| part_count | input | $clog2(MAX_PARTS+1) | Number of active partitions |
| row_valid | input | 1 | Row stream valid |
| row_data | input | LANES*LANE_W | One partition row, lane i in bits i*LANE_W upward |
| row_ready | output | 1 | Unit accepts a row |
| res_data | output | LANES*ACC_W | Result lanes |
| res_we | output | LANES | Per-lane write enable of the result |
| done | output | 1 | Result valid pulse |
| err | output | 1 | Illegal operation pulse |

## Verification
The bench sets up 8-bit lanes, with four lanes and six partitions per job. Each operation is run on patterns with mixed signs and high bits, so a signed and an unsigned compare, or sign and zero extension, give different answers. All-0x7F rows under a near-maximal scale push the average past 16 bits, which shows that the accumulator is wide and that it wraps. The expected results come from a model that folds partition-major across lanes. That order differs from the unit's internal grouping, so an order-dependent result would show. Counts of 0, 3 and 7 test the identities, ignored rows and clamping. Stalled rows, illegal codes and a start issued mid-job test the handshake.

// File: rtl/xpr_pkg.sv
`timescale 1ns/1ps
package xpr_pkg;
   localparam logic [2:0] OP_SUM = 3'd0;
   localparam logic [2:0] OP_AVG = 3'd1;
   localparam logic [2:0] OP_MAX = 3'd2;
   localparam logic [2:0] OP_OR  = 3'd3;
   localparam logic [2:0] OP_AND = 3'd4;
   localparam logic [2:0] OP_XOR = 3'd5;

   function automatic logic op_legal(input logic [2:0] op, input logic bw);
      return ((op <= OP_MAX) && !bw) || ((op >= OP_OR) && (op <= OP_XOR) && bw);
   endfunction

   function automatic logic op_narrow(input logic [2:0] op);
      return op >= OP_MAX;
   endfunction
endpackage

// File: rtl/xpr_prep.sv
`timescale 1ns/1ps
module xpr_prep
   import xpr_pkg::*;
#(
   parameter int LANE_W     = 16,
   parameter int ACC_W      = 32,
   parameter int SCALE_W    = 16,
   parameter int SCALE_FRAC = 8
) (
   input  logic [LANE_W-1:0]  raw,
   input  logic [2:0]         op,
   input  logic [SCALE_W-1:0] scale,
   output logic [ACC_W-1:0]   val
);
   localparam int PW = LANE_W + SCALE_W;

   logic signed [PW-1:0] a_ext;
   logic signed [PW-1:0] s_ext;
   logic signed [PW-1:0] prod;

   always_comb begin
      a_ext = PW'(signed'(raw));
      s_ext = PW'(signed'(scale));
      prod  = a_ext * s_ext;
      case (op)
         OP_SUM, OP_MAX: val = ACC_W'(signed'(raw));
         OP_AVG:         val = ACC_W'(prod >>> SCALE_FRAC);
         default:        val = ACC_W'(raw);
      endcase
   end
endmodule

// File: rtl/xpr_combine.sv
`timescale 1ns/1ps
module xpr_combine
   import xpr_pkg::*;
#(
   parameter int ACC_W = 32
) (
   input  logic [ACC_W-1:0] a,
   input  logic [ACC_W-1:0] b,
   input  logic [2:0]       op,
   output logic [ACC_W-1:0] y
);
   always_comb begin
      case (op)
         OP_SUM, OP_AVG: y = a + b;
         OP_MAX:         y = ($signed(a) > $signed(b)) ? a : b;
         OP_OR:          y = a | b;
         OP_AND:         y = a & b;
         OP_XOR:         y = a ^ b;
         default:        y = a;
      endcase
   end
endmodule

// File: rtl/xpart_reduce.sv
`timescale 1ns/1ps
module xpart_reduce
   import xpr_pkg::*;
#(
   parameter int LANE_W    = 16,
   parameter int LANES     = 8,
   parameter int MAX_PARTS = 16,
   parameter int ACC_W     = (LANE_W == 32) ? 32 : 2 * LANE_W,
   parameter int CNT_W     = $clog2(MAX_PARTS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start,
   input  logic [2:0]              op_code,
   input  logic                    bitwise_sel,
   input  logic                    axis_sel,
   input  logic [15:0]             scale,
   input  logic [CNT_W-1:0]        part_count,
   input  logic                    row_valid,
   input  logic [LANES*LANE_W-1:0] row_data,
   output logic                    row_ready,
   output logic [LANES*ACC_W-1:0]  res_data,
   output logic [LANES-1:0]        res_we,
   output logic                    done,
   output logic                    err
);
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MAX_PARTS - 1);

   if (!(LANE_W == 8 || LANE_W == 16 || LANE_W == 32)) begin : g_bad_lane_w
      $error("xpart_reduce: LANE_W must be 8, 16 or 32");
   end
   if (LANES < 1 || MAX_PARTS < 1) begin : g_bad_shape
      $error("xpart_reduce: LANES and MAX_PARTS must be positive");
   end
   if (ACC_W != ((LANE_W == 32) ? 32 : 2 * LANE_W)) begin : g_bad_acc
      $error("xpart_reduce: ACC_W must follow LANE_W");
   end

   typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_e;

   state_e           state;
   logic [2:0]       op_q;
   logic             axis_q;
   logic [15:0]      scale_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] idx_q;
   logic [ACC_W-1:0] acc      [LANES];
   logic [ACC_W-1:0] prep_val [LANES];
   logic [ACC_W-1:0] acc_next [LANES];
   logic [ACC_W-1:0] chain    [LANES];
   logic [LANES*ACC_W-1:0] res_next;
   logic             fire;

   function automatic logic [ACC_W-1:0] ident_of(input logic [2:0] op);
      logic [LANE_W-1:0] minv;
      minv = {1'b1, {(LANE_W-1){1'b0}}};
      case (op)
         OP_MAX:  return ACC_W'(signed'(minv));
         OP_AND:  return '1;
         default: return '0;
      endcase
   endfunction

   function automatic logic [ACC_W-1:0] trim(input logic [2:0] op, input logic [ACC_W-1:0] v);
      return op_narrow(op) ? ACC_W'(v[LANE_W-1:0]) : v;
   endfunction

   assign row_ready = (state == S_RUN);
   assign fire      = row_valid && row_ready;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      xpr_prep #(.LANE_W(LANE_W), .ACC_W(ACC_W), .SCALE_W(16), .SCALE_FRAC(8)) u_prep (
         .raw   (row_data[i*LANE_W +: LANE_W]),
         .op    (op_q),
         .scale (scale_q),
         .val   (prep_val[i])
      );
      xpr_combine #(.ACC_W(ACC_W)) u_acc_comb (
         .a  (acc[i]),
         .b  (prep_val[i]),
         .op (op_q),
         .y  (acc_next[i])
      );
   end

   assign chain[0] = acc[0];
   for (genvar i = 1; i < LANES; i++) begin : g_fold
      xpr_combine #(.ACC_W(ACC_W)) u_fold_comb (
         .a  (chain[i-1]),
         .b  (acc[i]),
         .op (op_q),
         .y  (chain[i])
      );
   end

   always_comb begin
      res_next = '0;
      if (axis_q) begin
         for (int i = 0; i < LANES; i++) res_next[i*ACC_W +: ACC_W] = trim(op_q, acc[i]);
      end else begin
         res_next[ACC_W-1:0] = trim(op_q, chain[LANES-1]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         op_q     <= '0;
         axis_q   <= 1'b0;
         scale_q  <= '0;
         cnt_q    <= '0;
         idx_q    <= '0;
         res_data <= '0;
         res_we   <= '0;
         done     <= 1'b0;
         err      <= 1'b0;
         for (int i = 0; i < LANES; i++) acc[i] <= '0;
      end else begin
         done   <= 1'b0;
         err    <= 1'b0;
         res_we <= '0;
         case (state)
            S_IDLE: if (start) begin
               if (op_legal(op_code, bitwise_sel)) begin
                  op_q    <= op_code;
                  axis_q  <= axis_sel;
                  scale_q <= scale;
                  cnt_q   <= part_count;
                  idx_q   <= '0;
                  for (int i = 0; i < LANES; i++) acc[i] <= ident_of(op_code);
                  state   <= S_RUN;
               end else begin
                  err <= 1'b1;
               end
            end
            S_RUN: if (fire) begin
               if (idx_q < cnt_q) begin
                  for (int i = 0; i < LANES; i++) acc[i] <= acc_next[i];
               end
               idx_q <= idx_q + 1'b1;
               if (idx_q == LAST_IDX) state <= S_FIN;
            end
            default: begin
               res_data <= res_next;
               res_we   <= axis_q ? '1 : LANES'(1);
               done     <= 1'b1;
               state    <= S_IDLE;
            end
         endcase
      end
   end

   // R2: an illegal request is flagged on the next cycle
   p_illegal_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state == S_IDLE && !op_legal(op_code, bitwise_sel)) |=> err);
   // R2: an error never coincides with a result or an open stream
   p_err_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!done && !row_ready));
   // R3: done is a single-cycle pulse
   p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R3: write enables only with done
   p_we_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|res_we) |-> done);
   // R5: per-lane result writes every lane
   p_vector_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && axis_q) |-> (&res_we));
   // R6: scalar result writes lane 0 only
   p_scalar_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !axis_q) |-> (res_we == LANES'(1)));
   // R11: a start during a job does not restart the stream
   p_busy_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_RUN && start && !fire) |=> (state == S_RUN && $stable(idx_q)));

   if (ACC_W > LANE_W) begin : g_narrow_chk
      // R9: maximum leaves the upper bits of lane 0 clear
      p_narrow_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (done && op_q == OP_MAX) |-> (res_data[ACC_W-1:LANE_W] == '0));
   end
endmodule

// File: tb/xpart_reduce_bench.sv
`timescale 1ns/1ps
module xpart_reduce_bench;
   localparam int LW = 8;
   localparam int NL = 4;
   localparam int NP = 6;
   localparam int AW = 16;
   localparam int CW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [2:0]    op_code = '0;
   logic          bitwise_sel = 1'b0;
   logic          axis_sel = 1'b0;
   logic [15:0]   scale = '0;
   logic [CW-1:0] part_count = '0;
   logic          row_valid = 1'b0;
   logic [NL*LW-1:0] row_data = '0;
   logic          row_ready;
   logic [NL*AW-1:0] res_data;
   logic [NL-1:0] res_we;
   logic          done;
   logic          err;

   int n_chk = 0;
   int n_err = 0;
   logic [7:0] rows [NP][NL];

   always #4 clk = ~clk;

   xpart_reduce #(.LANE_W(LW), .LANES(NL), .MAX_PARTS(NP)) u_xpart_reduce (
      .clk(clk), .rst_n(rst_n), .start(start), .op_code(op_code),
      .bitwise_sel(bitwise_sel), .axis_sel(axis_sel), .scale(scale),
      .part_count(part_count), .row_valid(row_valid), .row_data(row_data),
      .row_ready(row_ready), .res_data(res_data), .res_we(res_we),
      .done(done), .err(err)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] m_elem(input logic [2:0] op, input logic [7:0] r, input logic [15:0] sc);
      longint p;
      case (op)
         3'd0, 3'd2: return {{8{r[7]}}, r};
         3'd1: begin
            p = longint'($signed(r)) * longint'($signed(sc));
            p = p >>> 8;
            return p[15:0];
         end
         default: return {8'h00, r};
      endcase
   endfunction

   function automatic logic [15:0] m_comb(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
      case (op)
         3'd0, 3'd1: return a + b;
         3'd2: return ($signed(a) > $signed(b)) ? a : b;
         3'd3: return a | b;
         3'd4: return a & b;
         default: return a ^ b;
      endcase
   endfunction

   function automatic logic [15:0] m_ident(input logic [2:0] op);
      if (op == 3'd2) return 16'hFF80;
      if (op == 3'd4) return 16'hFFFF;
      return 16'h0000;
   endfunction

   function automatic logic [15:0] m_trim(input logic [2:0] op, input logic [15:0] v);
      return (op >= 3'd2) ? {8'h00, v[7:0]} : v;
   endfunction

   task automatic fill_const(input logic [7:0] v);
      for (int p = 0; p < NP; p++) for (int l = 0; l < NL; l++) rows[p][l] = v;
   endtask

   task automatic fill_mix(input int seed);
      for (int p = 0; p < NP; p++)
         for (int l = 0; l < NL; l++)
            rows[p][l] = 8'((seed * 37 + p * 53 + l * 29 + p * l * 11) ^ (seed << 3));
   endtask

   task automatic run_job(input logic [2:0] op, input bit bw, input bit ax, input logic [15:0] sc,
                          input int cnt, input bit gap, input bit busy_start, input string req);
      logic [15:0] ex [NL];
      logic [15:0] a;
      int n;
      n = (cnt > NP) ? NP : cnt;
      for (int l = 0; l < NL; l++) ex[l] = 16'h0;
      if (ax) begin
         for (int l = 0; l < NL; l++) begin
            a = m_ident(op);
            for (int p = 0; p < n; p++) a = m_comb(op, a, m_elem(op, rows[p][l], sc));
            ex[l] = m_trim(op, a);
         end
      end else begin
         a = m_ident(op);
         for (int p = 0; p < n; p++)
            for (int l = 0; l < NL; l++) a = m_comb(op, a, m_elem(op, rows[p][l], sc));
         ex[0] = m_trim(op, a);
      end
      @(negedge clk);
      start = 1'b1; op_code = op; bitwise_sel = bw; axis_sel = ax; scale = sc;
      part_count = CW'(cnt);
      @(negedge clk);
      start = 1'b0;
      chk(row_ready == 1'b1, {req, " R3 ready after start"}, 64'(row_ready), 64'd1);
      for (int p = 0; p < NP; p++) begin
         if (gap && p == 2) begin
            row_valid = 1'b0;
            @(negedge clk);
         end
         if (busy_start && p == 3) begin
            start = 1'b1; op_code = 3'd6; axis_sel = ~ax;
         end
         row_valid = 1'b1;
         for (int l = 0; l < NL; l++) row_data[l*LW +: LW] = rows[p][l];
         @(negedge clk);
         start = 1'b0; op_code = op; axis_sel = ax;
         chk(done == 1'b0 && err == 1'b0, {req, " R3/R11 no early done"}, 64'({done, err}), 64'd0);
      end
      row_valid = 1'b0;
      chk(done == 1'b0, {req, " R3 done not before finish"}, 64'(done), 64'd0);
      @(negedge clk);
      chk(done == 1'b1, {req, " R3 done timing"}, 64'(done), 64'd1);
      chk(res_we == (ax ? 4'hF : 4'h1), {req, (ax ? " R5 we" : " R6 we")}, 64'(res_we), 64'(ax ? 4'hF : 4'h1));
      for (int l = 0; l < NL; l++)
         chk(res_data[l*AW +: AW] == ex[l], {req, $sformatf(" lane %0d", l)}, 64'(res_data[l*AW +: AW]), 64'(ex[l]));
      @(negedge clk);
      chk(done == 1'b0 && res_we == '0, {req, " R3 single pulse"}, 64'({done, res_we}), 64'd0);
   endtask

   task automatic t_illegal(input logic [2:0] op, input bit bw, input string req);
      @(negedge clk);
      start = 1'b1; op_code = op; bitwise_sel = bw; axis_sel = 1'b1; part_count = 3'd6;
      @(negedge clk);
      start = 1'b0;
      row_valid = 1'b1;
      chk(err == 1'b1, {req, " R2 err raised"}, 64'(err), 64'd1);
      chk(row_ready == 1'b0, {req, " R2 no rows"}, 64'(row_ready), 64'd0);
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         chk(done == 1'b0 && row_ready == 1'b0 && err == 1'b0, {req, " R2 silent after err"},
             64'({done, row_ready, err}), 64'd0);
      end
      row_valid = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 0 && err == 0 && row_ready == 0 && res_we == 0, "R1 reset controls",
          64'({done, err, row_ready, res_we}), 64'd0);
      chk(res_data == '0, "R1 reset data", 64'(res_data), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      t_illegal(3'd6, 1'b0, "op6");
      t_illegal(3'd7, 1'b1, "op7");
      t_illegal(3'd0, 1'b1, "sum-as-bitwise");
      t_illegal(3'd4, 1'b0, "and-as-arith");

      fill_const(8'h7F);
      run_job(3'd0, 0, 0, 16'h0100, 6, 0, 0, "R7 sum widen scalar");
      run_job(3'd1, 0, 0, 16'h7FFF, 6, 0, 0, "R8 avg wrap scalar");
      fill_mix(1);
      run_job(3'd0, 0, 1, 16'h0100, 6, 1, 0, "R7 R5 sum lanes stall");
      run_job(3'd1, 0, 1, 16'hFE80, 6, 0, 0, "R8 avg negative scale");
      run_job(3'd2, 0, 1, 16'h0100, 6, 0, 0, "R9 max lanes");
      run_job(3'd2, 0, 0, 16'h0100, 6, 0, 0, "R9 R6 max scalar");
      fill_mix(5);
      run_job(3'd3, 1, 1, 16'h0100, 6, 0, 0, "R10 or lanes");
      run_job(3'd4, 1, 1, 16'h0100, 6, 0, 1, "R10 R11 and lanes busy start");
      run_job(3'd5, 1, 0, 16'h0100, 6, 0, 0, "R10 R6 xor scalar");
      fill_mix(9);
      run_job(3'd0, 0, 1, 16'h0100, 3, 0, 0, "R4 partial count");
      run_job(3'd4, 1, 1, 16'h0100, 0, 0, 0, "R4 and identity");
      run_job(3'd2, 0, 0, 16'h0100, 0, 0, 0, "R4 max identity");
      run_job(3'd5, 1, 1, 16'h0100, 7, 0, 0, "R4 count clamp");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule